// File: doc/BRIEF.md
# Compute Unit Idle Timeout Monitor

This block watches the wave slots of one compute unit and tells a larger chip when the whole unit has sat idle for too long. Each cycle it receives up to `LANES` slot status-change reports. Each report carries the slot's previous state and its new state. From these reports it keeps a running count of idle slots. It records the time at which that count last reached the programmed number of slots. When the unit leaves such an all-idle period, it compares the elapsed time against a programmable limit.

The limit is checked at one moment only: when a slot leaves idle while every slot is idle. The elapsed time is measured from the instant the last slot went idle. A limit of zero switches monitoring off entirely. Two further conditions are reported as a sticky fault: the counter would exceed the slot total, or it would drop below zero. Either condition reveals inconsistent status reports from the scheduler.

Top module: `cu_idle_watch`

## Requirements
- R1: State codes are 3 bits: 0 stopped, 1 running, 2 stalled, 3 waiting on a counter, 4 barrier, 5 returning, 6 and 7 spare. Codes 0, 2, 3 and 4 are idle; all others are active.
- R2: While `timeout_limit` is zero, all reports are ignored and `idle_count`, `idle_since` and both flags keep their values.
- R3: A valid report whose new state is idle and differs from the old state counts as one idle entry. This includes a change between two different idle states, which counts as an entry only.
- R4: A valid report whose old state is idle, whose new state is active, and which is not an entry counts as one idle exit.
- R5: A report with equal old and new states, or with its valid bit low, changes nothing.
- R6: All entries and exits of one cycle are applied together, so the count changes by entries minus exits. `idle_count` shows the result one clock edge later.
- R7: When the count after an update with at least one entry equals `slot_total`, `idle_since` takes the current `now_time` at that edge.
- R8: `timeout_err` is set at an edge with at least one exit if both of these hold: `idle_count` equalled `slot_total` before the update, and `now_time - idle_since` (modulo 2^TIME_W) is at least `timeout_limit`. It is not set when the elapsed time is smaller.
- R9: `timeout_err` stays high until reset.
- R10: If entries minus exits would take the count below zero, the count is held at zero. If it would take the count above `slot_total`, the count is held at `slot_total`. In both cases `count_fault` is set and stays high until reset.
- R11: After reset, `idle_count`, `idle_since`, `timeout_err` and `count_fault` are zero.
- R12: `all_idle` is high exactly when `idle_count` equals `slot_total`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | LANES | One valid bit per report lane |
| evt_old | input | 3*LANES | Previous state per lane, lane i at bits [3i+2:3i] |
| evt_new | input | 3*LANES | New state per lane, same packing |
| slot_total | input | CNT_W | Number of wave slots in the unit |
| now_time | input | TIME_W | Free-running time counter |
| timeout_limit | input | TIME_W | Idle time limit; zero disables monitoring |
| idle_count | output | CNT_W | Current idle slot count |
| all_idle | output | 1 | Count equals slot total |
| idle_since | output | TIME_W | Time at which all slots last became idle |
| timeout_err | output | 1 | Sticky timeout error |
| count_fault | output | 1 | Sticky counter range fault |

## Verification
The bound checker enforces several properties on every cycle:
- both flags stay sticky;
- the count stays still without qualifying reports or while disabled;
- the count never passes the previous slot total;
- an entry below the total always grows the count;
- the timestamp moves only after an entry that filled the unit;
- the error rises only after an exit from an all-idle period.

Other behaviours need the bench's scenarios and its cycle-by-cycle reference model. These include the exact count arithmetic when entries and exits mix in one cycle, and the idle-to-idle entry rule. They also include both sides of the timeout threshold and the clamping values after underflow and overflow.

// File: rtl/cuiw_pkg.sv
package cuiw_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    WS_STOPPED   = 3'd0,
    WS_RUNNING   = 3'd1,
    WS_STALLED   = 3'd2,
    WS_WAITCNT   = 3'd3,
    WS_BARRIER   = 3'd4,
    WS_RETURNING = 3'd5,
    WS_SPARE6    = 3'd6,
    WS_SPARE7    = 3'd7
  } wave_state_e;

  // R1: idle class membership
  function automatic logic state_is_idle(input logic [STATE_W-1:0] s);
    return (s == WS_STOPPED) || (s == WS_STALLED) ||
           (s == WS_WAITCNT) || (s == WS_BARRIER);
  endfunction

endpackage

// File: rtl/cuiw_lane_decode.sv
module cuiw_lane_decode
  import cuiw_pkg::*;
(
  input  logic               valid,
  input  logic [STATE_W-1:0] old_state,
  input  logic [STATE_W-1:0] new_state,
  output logic               enter_idle,
  output logic               leave_idle
);

  logic changed;

  always_comb begin
    changed    = valid && (old_state != new_state);          // R5
    enter_idle = changed && state_is_idle(new_state);        // R3
    leave_idle = changed && !state_is_idle(new_state)
                 && state_is_idle(old_state);                 // R4
  end

endmodule

// File: rtl/cuiw_tally.sv
module cuiw_tally #(
  parameter int LANES = 4,
  localparam int SUM_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] flags,
  output logic [SUM_W-1:0] total
);

  function automatic logic [SUM_W-1:0] count_ones(input logic [LANES-1:0] v);
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < LANES; i++) begin
      acc = acc + SUM_W'(v[i]);
    end
    return acc;
  endfunction

  assign total = count_ones(flags);

endmodule

// File: rtl/cuiw_idle_tracker.sv
module cuiw_idle_tracker #(
  parameter int CNT_W  = 6,
  parameter int TIME_W = 16,
  parameter int SUM_W  = 3,
  localparam int WIDE_W = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [SUM_W-1:0]  enter_sum,
  input  logic [SUM_W-1:0]  leave_sum,
  input  logic [CNT_W-1:0]  slot_total,
  input  logic [TIME_W-1:0] now_time,
  input  logic [TIME_W-1:0] timeout_limit,
  output logic [CNT_W-1:0]  idle_count,
  output logic [TIME_W-1:0] idle_since,
  output logic              timeout_err,
  output logic              count_fault,
  output logic              all_idle_now,
  output logic              limit_reached,
  output logic              trip,
  output logic              take_stamp,
  output logic              under_range,
  output logic              over_range
);

  logic signed [WIDE_W-1:0] raw_next;
  logic [CNT_W-1:0]         next_count;

  // elapsed time, modulo 2^TIME_W
  function automatic logic [TIME_W-1:0] time_gap(input logic [TIME_W-1:0] t_now,
                                                input logic [TIME_W-1:0] t_mark);
    return t_now - t_mark;
  endfunction

  // count plus entries minus exits, kept signed and wide
  function automatic logic signed [WIDE_W-1:0] apply_delta(input logic [CNT_W-1:0] c,
                                                          input logic [SUM_W-1:0] up,
                                                          input logic [SUM_W-1:0] dn);
    return $signed({2'b00, c}) + $signed(WIDE_W'(up)) - $signed(WIDE_W'(dn));
  endfunction

  always_comb begin
    all_idle_now  = (idle_count == slot_total);
    limit_reached = time_gap(now_time, idle_since) >= timeout_limit;
    trip          = enable && (leave_sum != '0) && all_idle_now && limit_reached;  // R8
    raw_next      = apply_delta(idle_count, enter_sum, leave_sum);
    under_range   = enable && (raw_next < 0);                                      // R10
    over_range    = enable && (raw_next > $signed({2'b00, slot_total}));
    if (under_range)     next_count = '0;
    else if (over_range) next_count = slot_total;
    else                 next_count = raw_next[CNT_W-1:0];
    take_stamp    = enable && (enter_sum != '0) && (next_count == slot_total);    // R7
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_count  <= '0;
      idle_since  <= '0;
      timeout_err <= 1'b0;
      count_fault <= 1'b0;
    end else if (enable) begin
      idle_count <= next_count;
      if (take_stamp) idle_since <= now_time;
      if (trip) timeout_err <= 1'b1;
      if (under_range || over_range) count_fault <= 1'b1;
    end
  end

endmodule

// File: rtl/cu_idle_watch.sv
module cu_idle_watch
  import cuiw_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int CNT_W  = 6,
  parameter int TIME_W = 16,
  localparam int SUM_W = $clog2(LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       evt_valid,
  input  logic [3*LANES-1:0]     evt_old,
  input  logic [3*LANES-1:0]     evt_new,
  input  logic [CNT_W-1:0]       slot_total,
  input  logic [TIME_W-1:0]      now_time,
  input  logic [TIME_W-1:0]      timeout_limit,
  output logic [CNT_W-1:0]       idle_count,
  output logic                   all_idle,
  output logic [TIME_W-1:0]      idle_since,
  output logic                   timeout_err,
  output logic                   count_fault
);

  logic [LANES-1:0] enter_vec;
  logic [LANES-1:0] leave_vec;
  logic [SUM_W-1:0] enter_sum;
  logic [SUM_W-1:0] leave_sum;
  logic             enable;
  logic             enter_any;
  logic             leave_any;
  logic             all_idle_now;
  logic             limit_reached;
  logic             trip;
  logic             take_stamp;
  logic             under_range;
  logic             over_range;

  assign enable    = (timeout_limit != '0);   // R2
  assign enter_any = |enter_vec;
  assign leave_any = |leave_vec;
  assign all_idle  = all_idle_now;            // R12

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cuiw_lane_decode u_dec (
      .valid      (evt_valid[g]),
      .old_state  (evt_old[STATE_W*g +: STATE_W]),
      .new_state  (evt_new[STATE_W*g +: STATE_W]),
      .enter_idle (enter_vec[g]),
      .leave_idle (leave_vec[g])
    );
  end

  cuiw_tally #(.LANES(LANES)) u_enter_tally (
    .flags (enter_vec),
    .total (enter_sum)
  );

  cuiw_tally #(.LANES(LANES)) u_leave_tally (
    .flags (leave_vec),
    .total (leave_sum)
  );

  cuiw_idle_tracker #(
    .CNT_W  (CNT_W),
    .TIME_W (TIME_W),
    .SUM_W  (SUM_W)
  ) u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .enter_sum     (enter_sum),
    .leave_sum     (leave_sum),
    .slot_total    (slot_total),
    .now_time      (now_time),
    .timeout_limit (timeout_limit),
    .idle_count    (idle_count),
    .idle_since    (idle_since),
    .timeout_err   (timeout_err),
    .count_fault   (count_fault),
    .all_idle_now  (all_idle_now),
    .limit_reached (limit_reached),
    .trip          (trip),
    .take_stamp    (take_stamp),
    .under_range   (under_range),
    .over_range    (over_range)
  );

endmodule

// File: rtl/cuiw_checks.sv
module cuiw_checks #(
  parameter int CNT_W  = 6,
  parameter int TIME_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enter_any,
  input logic              leave_any,
  input logic [CNT_W-1:0]  slot_total,
  input logic [TIME_W-1:0] timeout_limit,
  input logic [CNT_W-1:0]  idle_count,
  input logic              all_idle,
  input logic [TIME_W-1:0] idle_since,
  input logic              timeout_err,
  input logic              count_fault
);

  assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_limit == '0) |=> $stable(idle_count));

  assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!enter_any && !leave_any) |=> $stable(idle_count));

  assert_entry_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((timeout_limit != '0) && enter_any && !leave_any && (idle_count < slot_total))
    |=> (idle_count > $past(idle_count)));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (idle_count <= $past(slot_total)));

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    count_fault |=> count_fault);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> $past(leave_any && all_idle && (timeout_limit != '0)));

  assert_stamp_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idle_since) |-> ($past(enter_any) && (idle_count == $past(slot_total))));

endmodule

bind cu_idle_watch cuiw_checks #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .enter_any     (enter_any),
  .leave_any     (leave_any),
  .slot_total    (slot_total),
  .timeout_limit (timeout_limit),
  .idle_count    (idle_count),
  .all_idle      (all_idle),
  .idle_since    (idle_since),
  .timeout_err   (timeout_err),
  .count_fault   (count_fault)
);

// File: tb/tb_cu_idle_watch.sv
module tb_cu_idle_watch;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int CNT_W = 6;
  localparam int TIME_W = 16;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LANES-1:0] ev = '0;
  logic [3*LANES-1:0] eo = '0;
  logic [3*LANES-1:0] en = '0;
  logic [CNT_W-1:0] tot = 6'd3;
  logic [TIME_W-1:0] now_t = '0;
  logic [TIME_W-1:0] lim = '0;
  logic [CNT_W-1:0] idle_count;
  logic all_idle;
  logic [TIME_W-1:0] idle_since;
  logic timeout_err;
  logic count_fault;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  string phase = "R11";

  // reference model state
  int m_cnt = 0;
  int m_since = 0;
  bit m_err = 0;
  bit m_fault = 0;

  cu_idle_watch #(.LANES(LANES), .CNT_W(CNT_W), .TIME_W(TIME_W)) dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(ev), .evt_old(eo), .evt_new(en),
    .slot_total(tot), .now_time(now_t), .timeout_limit(lim),
    .idle_count(idle_count), .all_idle(all_idle), .idle_since(idle_since),
    .timeout_err(timeout_err), .count_fault(count_fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit quiet_state(input int s);
    case (s)
      0, 2, 3, 4: return 1'b1;
      default:    return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_since = 0; m_err = 0; m_fault = 0;
    end else if (lim != 0) begin
      int ups, downs, nxt;
      ups = 0; downs = 0;
      for (int i = 0; i < LANES; i++) begin
        int o, n;
        o = int'(eo[3*i +: 3]);
        n = int'(en[3*i +: 3]);
        if (ev[i] && o != n) begin
          if (quiet_state(n)) ups++;
          else if (quiet_state(o)) downs++;
        end
      end
      if (downs > 0 && m_cnt == int'(tot) &&
          ((int'(now_t) - m_since) & 16'hFFFF) >= int'(lim)) m_err = 1;
      nxt = m_cnt + ups - downs;
      if (nxt < 0) begin nxt = 0; m_fault = 1; end
      else if (nxt > int'(tot)) begin nxt = int'(tot); m_fault = 1; end
      if (ups > 0 && nxt == int'(tot)) m_since = int'(now_t);
      m_cnt = nxt;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      cyc++;
      now_t <= now_t + 1'b1;
      checks++;
      if (int'(idle_count) != m_cnt || all_idle != (m_cnt == int'(tot)) ||
          int'(idle_since) != m_since || timeout_err != m_err || count_fault != m_fault) begin
        errors++;
        $display("FAIL %s model: cnt=%0d/%0d all=%0b/%0b since=%0d/%0d err=%0b/%0b fault=%0b/%0b",
                 phase, idle_count, m_cnt, all_idle, (m_cnt == int'(tot)), idle_since, m_since,
                 timeout_err, m_err, count_fault, m_fault);
      end
      if (cyc > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WATCHDOG);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic check_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input int lane, input int o, input int n);
    ev[lane] = 1'b1;
    eo[3*lane +: 3] = 3'(o);
    en[3*lane +: 3] = 3'(n);
  endtask

  task automatic step();
    @(negedge clk);
    #1;
    ev = '0;
  endtask

  task automatic idle_cycles(input int k);
    for (int i = 0; i < k; i++) step();
  endtask

  initial begin
    step(); step();
    phase = "R11";
    check_val("R11 count", int'(idle_count), 0);
    check_val("R11 err", int'(timeout_err), 0);
    check_val("R11 fault", int'(count_fault), 0);
    rst_n = 1'b1;
    step();
    check_val("R11 since", int'(idle_since), 0);

    phase = "R2";
    lim = '0;
    put(0, 1, 0); step();
    check_val("R2 disabled count", int'(idle_count), 0);

    lim = 16'd20;
    phase = "R3";
    put(0, 1, 0); step();
    check_val("R3 entry", int'(idle_count), 1);

    phase = "R5";
    put(1, 1, 1); put(2, 2, 2); step();
    check_val("R5 same state", int'(idle_count), 1);

    phase = "R3";
    put(0, 0, 4); step();
    check_val("R3 idle to idle", int'(idle_count), 2);

    phase = "R6";
    put(1, 1, 3); put(2, 1, 2); put(3, 2, 1); step();
    check_val("R6 mixed", int'(idle_count), 3);
    check_val("R12 all idle", int'(all_idle), 1);
    check_val("R6 no err", int'(timeout_err), 0);

    phase = "R8";
    idle_cycles(3);
    put(1, 3, 1); step();
    check_val("R4 exit", int'(idle_count), 2);
    check_val("R8 short no err", int'(timeout_err), 0);
    check_val("R12 not all idle", int'(all_idle), 0);

    phase = "R7";
    put(1, 1, 0); step();
    check_val("R7 refill", int'(idle_count), 3);
    idle_cycles(25);
    phase = "R8";
    put(1, 0, 1); step();
    check_val("R8 err set", int'(timeout_err), 1);
    check_val("R8 count", int'(idle_count), 2);

    phase = "R9";
    put(1, 1, 0); step();
    put(1, 0, 1); step();
    idle_cycles(3);
    check_val("R9 sticky", int'(timeout_err), 1);

    phase = "R10";
    put(0, 4, 1); put(2, 2, 1); put(3, 3, 1); step();
    check_val("R10 underflow clamp", int'(idle_count), 0);
    check_val("R10 underflow fault", int'(count_fault), 1);

    rst_n = 1'b0; step();
    tot = 6'd1;
    rst_n = 1'b1; step();
    check_val("R11 fault cleared", int'(count_fault), 0);
    put(0, 1, 0); put(1, 1, 2); step();
    check_val("R10 overflow clamp", int'(idle_count), 1);
    check_val("R10 overflow fault", int'(count_fault), 1);
    idle_cycles(2);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule